// File: doc/BRIEF.md
# Peripheral Control Line Function Unit

This block serves one DMA channel's multi-purpose peripheral control pin. The pin can take one of six roles. A two-bit device-type field and a two-bit line-function field choose the role. Two of the device types take over the pin regardless of the line function: one makes it an enable clock input and the other makes it an active-low ready input. For the other device types, the line function picks one of four roles: level status input, interrupt input, start pulse output or abort input.

The raw pin passes through a two-flop synchronizer before anything else looks at it. A falling edge counts only when the synchronized level then stays low for two clocks. In the status role or the interrupt role, such a qualified edge sets a sticky transition-seen flag. In the interrupt role, that flag also raises the interrupt request. The abort role listens only after the channel has been started. In that role a qualified edge latches an abort request and disarms the role. The start pulse role drives the pin low for exactly `PULSE_CYCLES` clocks, starting on the channel-start strobe. The pin's output enable is high only in this role.

Top module: `pcl_unit`

## Requirements
- R1: `stat_lvl` follows the pin level through two synchronizing flops, in every role. A change on `pcl_in` appears after two clock edges.
- R2: In the status role (`line_fn`=00) or the interrupt role (`line_fn`=01), `seen` goes high four clock edges after the pin falls, provided the pin stays low. A low lasting one clock leaves `seen` at 0.
- R3: `seen` stays set until the clock edge that samples `clr` high, and then it reads 0.
- R4: In the interrupt role, `irq` is high whenever `seen` is high. In the status role, `irq` stays 0 even when `seen` is set.
- R5: In the start pulse role (`line_fn`=10), a one-cycle `chan_start` drives `pcl_out` low for exactly `PULSE_CYCLES` (8) clocks from the next edge. At all other times `pcl_out` is high, and `pcl_oe` is high.
- R6: In the abort role (`line_fn`=11), a qualified falling edge sets `abort_req` only after `chan_start` has been seen. Edges before that have no effect. Once `abort_req` is set, `clr` clears it. The role then needs a new `chan_start` before a further edge can set `abort_req`.
- R7: Device type 01 makes the pin an enable input. `enable` equals the synchronized level, and the line function is ignored: no `seen`, no abort and no drive.
- R8: Device type 10 makes the pin an active-low ready input. `ready` is the inverse of the synchronized level, and the line function is ignored.
- R9: `pcl_oe` is 0 in every role other than the start pulse role. This includes device types 01 and 10 with `line_fn`=10.
- R10: After reset, `seen`, `irq`, `abort_req`, `pcl_oe` are 0 and `pcl_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_type | input | 2 | Device type: 01 enable clock, 10 ready, 00/11 use line_fn |
| line_fn | input | 2 | Line role: 00 status, 01 interrupt, 10 start pulse, 11 abort |
| chan_start | input | 1 | One-cycle channel activation strobe |
| clr | input | 1 | Status register write strobe, clears seen and abort |
| pcl_in | input | 1 | Pin input level |
| pcl_out | output | 1 | Pin output level |
| pcl_oe | output | 1 | Pin output enable |
| stat_lvl | output | 1 | Synchronized pin level |
| seen | output | 1 | Qualified falling edge seen |
| irq | output | 1 | Interrupt request |
| abort_req | output | 1 | Abort error request |
| ready | output | 1 | Ready, active high |
| enable | output | 1 | Enable clock level |

## Verification
The pulse-length assertion expects no second `chan_start` while a pulse is still running, because a second strobe would restart the pulse and stretch it. The bench issues each strobe only once the pin is idle. The checks also expect the pin to be high through reset, so that a low level already present at reset is not taken for a falling edge. The bench holds `pcl_in` high until reset is released. The bench keeps `dev_type` and `line_fn` steady while a qualified edge or a pulse is in flight. It changes them only between test steps.

// File: rtl/pcl_unit.sv
module pcl_unit #(
  parameter int QUAL_CYCLES  = 2,
  parameter int PULSE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] dev_type,
  input  logic [1:0] line_fn,
  input  logic       chan_start,
  input  logic       clr,
  input  logic       pcl_in,
  output logic       pcl_out,
  output logic       pcl_oe,
  output logic       stat_lvl,
  output logic       seen,
  output logic       irq,
  output logic       abort_req,
  output logic       ready,
  output logic       enable
);
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam int PW = $clog2(PULSE_CYCLES + 1);

  logic          sync1, sync2;
  logic [QW-1:0] low_cnt;
  logic [PW-1:0] pulse_cnt;
  logic          armed;

  wire is_en   = (dev_type == 2'b01);
  wire is_rdy  = (dev_type == 2'b10);
  wire prog    = !is_en && !is_rdy;
  wire m_stat  = prog && (line_fn == 2'b00);
  wire m_irq   = prog && (line_fn == 2'b01);
  wire m_pulse = prog && (line_fn == 2'b10);
  wire m_abort = prog && (line_fn == 2'b11);

  wire qual       = !sync2 && (low_cnt == QW'(QUAL_CYCLES - 1));
  wire abort_fire = qual && m_abort && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= pcl_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      low_cnt <= '0;
    else if (sync2)
      low_cnt <= '0;
    else if (low_cnt != QW'(QUAL_CYCLES))
      low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      seen <= 1'b0;
    else if (qual && (m_stat || m_irq))
      seen <= 1'b1;
    else if (clr)
      seen <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      abort_req <= 1'b0;
    end else begin
      if (chan_start)      armed <= 1'b1;
      else if (abort_fire) armed <= 1'b0;
      if (abort_fire)      abort_req <= 1'b1;
      else if (clr)        abort_req <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pulse_cnt <= '0;
    else if (chan_start && m_pulse)
      pulse_cnt <= PW'(PULSE_CYCLES);
    else if (pulse_cnt != '0)
      pulse_cnt <= pulse_cnt - 1'b1;
  end

  assign stat_lvl = sync2;
  assign irq      = seen && m_irq;
  assign ready    = is_rdy && !sync2;
  assign enable   = is_en && sync2;
  assign pcl_oe   = m_pulse;
  assign pcl_out  = (pulse_cnt == '0);
endmodule

module pcl_unit_chk #(
  parameter int PULSE_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] dev_type,
  input logic [1:0] line_fn,
  input logic       clr,
  input logic       pcl_out,
  input logic       pcl_oe,
  input logic       seen,
  input logic       abort_req,
  input logic       ready,
  input logic       enable
);
  localparam int RW = $clog2(PULSE_CYCLES + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run <= '0;
    else if (pcl_oe && !pcl_out) begin
      if (run != RW'(PULSE_CYCLES + 1)) run <= run + 1'b1;
    end else                   run <= '0;
  end

  assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(PULSE_CYCLES));

  assert_pulse_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pcl_oe && $rose(pcl_out)) |-> ($past(run) == RW'(PULSE_CYCLES - 1)));

  assert_seen_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !clr) |=> seen);

  assert_abort_role_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_req) |-> ($past(line_fn) == 2'b11 && $past(dev_type) != 2'b01
                          && $past(dev_type) != 2'b10));

  assert_oe_role_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pcl_oe |-> (line_fn == 2'b10 && dev_type != 2'b01 && dev_type != 2'b10));

  assert_rdy_en_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ready, enable}));
endmodule

bind pcl_unit pcl_unit_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_type(dev_type), .line_fn(line_fn), .clr(clr),
  .pcl_out(pcl_out), .pcl_oe(pcl_oe), .seen(seen), .abort_req(abort_req),
  .ready(ready), .enable(enable)
);

// File: tb/pcl_unit_bench.sv
module pcl_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] dev_type = 2'b00;
  logic [1:0] line_fn = 2'b00;
  logic       chan_start = 1'b0;
  logic       clr = 1'b0;
  logic       pcl_in = 1'b1;
  logic       pcl_out, pcl_oe, stat_lvl, seen, irq, abort_req, ready, enable;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  pcl_unit u_pcl_unit (
    .clk(clk), .rst_n(rst_n), .dev_type(dev_type), .line_fn(line_fn),
    .chan_start(chan_start), .clr(clr), .pcl_in(pcl_in), .pcl_out(pcl_out),
    .pcl_oe(pcl_oe), .stat_lvl(stat_lvl), .seen(seen), .irq(irq),
    .abort_req(abort_req), .ready(ready), .enable(enable)
  );

  // {dev_type, line_fn, pin, exp_ready, exp_enable, exp_oe}; stat_lvl expected = pin
  localparam int NV = 9;
  localparam logic [7:0] VEC [NV] = '{
    {2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'b01, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'b10, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b10, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'b00, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'b11, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'b00, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic strobe_clr();
    clr = 1'b1; tick(1); clr = 1'b0;
  endtask

  task automatic strobe_start();
    chan_start = 1'b1; tick(1); chan_start = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    // R10 reset state
    chk("R10 seen", seen, 1'b0);
    chk("R10 irq", irq, 1'b0);
    chk("R10 abort", abort_req, 1'b0);
    chk("R10 oe", pcl_oe, 1'b0);
    chk("R10 out", pcl_out, 1'b1);
    rst_n = 1'b1;
    tick(2);

    // table: R1 level, R7 enable, R8 ready, R9 oe
    for (int i = 0; i < NV; i++) begin
      dev_type = VEC[i][7:6];
      line_fn  = VEC[i][5:4];
      pcl_in   = VEC[i][3];
      tick(3);
      chk("R1 stat_lvl", stat_lvl, VEC[i][3]);
      chk("R8 ready", ready, VEC[i][2]);
      chk("R7 enable", enable, VEC[i][1]);
      chk("R9 oe", pcl_oe, VEC[i][0]);
    end
    dev_type = 2'b00; line_fn = 2'b00; pcl_in = 1'b1;
    tick(3);
    strobe_clr();
    tick(1);

    // R1 latency: two edges
    pcl_in = 1'b0;
    tick(1);
    chk("R1 one edge", stat_lvl, 1'b1);
    tick(1);
    chk("R1 two edges", stat_lvl, 1'b0);
    pcl_in = 1'b1; tick(4); strobe_clr(); tick(1);

    // R2 short glitch ignored
    pcl_in = 1'b0; tick(1); pcl_in = 1'b1;
    tick(6);
    chk("R2 glitch", seen, 1'b0);

    // R2 qualified edge in status role, R4 no irq
    pcl_in = 1'b0;
    tick(3);
    chk("R2 early", seen, 1'b0);
    tick(1);
    chk("R2 seen", seen, 1'b1);
    chk("R4 status no irq", irq, 1'b0);
    pcl_in = 1'b1; tick(3);
    chk("R3 sticky", seen, 1'b1);
    strobe_clr();
    chk("R3 cleared", seen, 1'b0);

    // R4 interrupt role
    line_fn = 2'b01;
    pcl_in = 1'b0; tick(4);
    chk("R4 irq", irq, 1'b1);
    pcl_in = 1'b1; tick(3);
    strobe_clr();
    chk("R4 irq cleared", irq, 1'b0);

    // R7 enable type ignores line_fn
    dev_type = 2'b01;
    pcl_in = 1'b0; tick(6);
    chk("R7 no seen", seen, 1'b0);
    chk("R7 enable low", enable, 1'b0);
    pcl_in = 1'b1; tick(3);
    chk("R7 enable high", enable, 1'b1);

    // R8 ready type with abort role programmed: ignored
    dev_type = 2'b10; line_fn = 2'b11;
    strobe_start();
    pcl_in = 1'b0; tick(6);
    chk("R8 ready", ready, 1'b1);
    chk("R8 no abort", abort_req, 1'b0);
    pcl_in = 1'b1; tick(3);
    dev_type = 2'b00;
    strobe_clr();

    // R6 abort role: reset-disarm by prior strobe already used; reset first
    rst_n = 1'b0; tick(1); rst_n = 1'b1; tick(3);
    line_fn = 2'b11;
    pcl_in = 1'b0; tick(6);
    chk("R6 unarmed", abort_req, 1'b0);
    pcl_in = 1'b1; tick(3);
    strobe_start();
    pcl_in = 1'b0; tick(4);
    chk("R6 abort", abort_req, 1'b1);
    pcl_in = 1'b1; tick(3);
    strobe_clr();
    chk("R6 cleared", abort_req, 1'b0);
    pcl_in = 1'b0; tick(6);
    chk("R6 disarmed", abort_req, 1'b0);
    pcl_in = 1'b1; tick(3);

    // R5 start pulse
    line_fn = 2'b10;
    tick(1);
    chk("R5 idle high", pcl_out, 1'b1);
    chk("R5 oe", pcl_oe, 1'b1);
    strobe_start();
    chk("R5 first low", pcl_out, 1'b0);
    tick(7);
    chk("R5 eighth low", pcl_out, 1'b0);
    tick(1);
    chk("R5 ends", pcl_out, 1'b1);
    tick(4);
    chk("R5 stays high", pcl_out, 1'b1);

    // R9 pulse role overridden by device type
    dev_type = 2'b10; tick(1);
    chk("R9 ready type oe", pcl_oe, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule